// File: doc/BRIEF.md
# Three-Wire Half-Duplex SPI Master

This block is a serial master for one peripheral on a three-wire bus. Data in both directions uses a single open-drain data line. The line floats high through a pull-up, and either end can pull it low. A transaction writes a command of up to 16 bits and then reads a response of up to 16 bits. Chip select stays low for the whole exchange. The serial clock runs in mode 0.

The host loads the write word and both lengths, then pulses `start`. `busy` stays high while the exchange runs. A one-cycle `done` pulse marks the end, and the response appears on `rd_data` in the same cycle. The master controls the line only through `sdio_pull`: a 1 pulls the line low and a 0 releases it. The board returns the line through an inverting buffer, so `sdio_inv` is the complement of the true line level. Four supply pins stay high at all times to power the peripheral.

Top module: `spi3w_master`

## Requirements
- R1: `pwr` is 4'b1111 in every cycle, including during reset.
- R2: When idle, `cs_n` is 1, `sclk` is 0, `sdio_pull` is 0 and `busy` is 0.
- R3: The serial clock idles low. Each high half and each low half lasts DIV clock cycles. `sdio_pull` changes only while `sclk` is low.
- R4: `cs_n` is 0 from the cycle after `start` until `done`. `sclk` is low for exactly DIV cycles after `cs_n` falls and for exactly DIV cycles before `cs_n` rises.
- R5: The write phase sends `wr_data[wl-1]` down to `wr_data[0]`, most significant bit first, one bit per clock period. A 0 bit sets `sdio_pull` to 1 and a 1 bit sets it to 0. Bits of `wr_data` at position wl and above are never sent.
- R6: During the read phase `sdio_pull` stays 0. At each rising `sclk` edge the master takes the inverse of `sdio_inv` as the received bit. The first received bit ends at `rd_data[rl-1]` and the last at `rd_data[0]`. All bits above rl-1 are 0.
- R7: A write length of 0 starts with the read phase. With both lengths 0, chip select still pulses low and `done` still fires, but `sclk` never rises.
- R8: A `wr_len` or `rd_len` value above 16 is treated as 16.
- R9: `busy` is 1 in the cycle after `start` is sampled. `done` is high for one cycle only. In that cycle `busy` is 0 and `rd_data` holds the new word.
- R10: A `start` pulse while `busy` is 1 has no effect. No extra transaction follows, and the running transaction sends and receives exactly what it was started with.
- R11: Each transaction has exactly wl+rl rising `sclk` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a transaction when idle |
| wr_len | input | 5 | Write bit count (clamped to 16) |
| rd_len | input | 5 | Read bit count (clamped to 16) |
| wr_data | input | 16 | Command word, low wr_len bits sent |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Received word, right-aligned |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, mode 0 |
| sdio_pull | output | 1 | 1 pulls the shared data line low |
| sdio_inv | input | 1 | Inverted readback of the shared data line |
| pwr | output | 4 | Peripheral supply pins, always high |

## Verification
The bench models the wired-low line and the inverting readback, so a design that forgets the inversion reads back every response complemented. The tests target the zero-length write, where the first rising edge must already carry response data. They also target the zero/zero case, where chip select must pulse with no clock, and lengths above 16, which must clamp rather than wrap. A master that keeps driving into the read phase corrupts the response and is flagged. So is a design that latches a second `start` during a transfer: the scoreboard sees the corrupted transfer or an unexpected extra chip-select pulse. The bench measures the lead and trail gaps around chip select and the spacing of the rising edges, which catches an off-by-one in the divider.

// File: rtl/spi3w_master.sv
module spi3w_master #(
  parameter int DIV    = 4,
  parameter int MAXLEN = 16,
  localparam int LENW  = $clog2(MAXLEN + 1),
  localparam int IDXW  = $clog2(2 * MAXLEN + 1),
  localparam int CW    = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LENW-1:0]   wr_len,
  input  logic [LENW-1:0]   rd_len,
  input  logic [MAXLEN-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic [MAXLEN-1:0] rd_data,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdio_pull,
  input  logic              sdio_inv,
  output logic [3:0]        pwr
);

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_TAIL} st_t;

  st_t               state;
  logic [CW-1:0]     cnt;
  logic [IDXW-1:0]   idx;
  logic [LENW-1:0]   wl_q, rl_q;
  logic [MAXLEN-1:0] wr_sh, rd_sh;

  wire [LENW-1:0] wl_c  = (wr_len > LENW'(MAXLEN)) ? LENW'(MAXLEN) : wr_len;
  wire [LENW-1:0] rl_c  = (rd_len > LENW'(MAXLEN)) ? LENW'(MAXLEN) : rd_len;
  wire [IDXW-1:0] total = IDXW'(wl_q) + IDXW'(rl_q);
  wire            tick  = (cnt == CW'(DIV - 1));
  wire            in_wr = (idx < IDXW'(wl_q));
  wire            last  = ((idx + 1'b1) == total);
  wire            rx_bit = ~sdio_inv;

  assign pwr       = 4'b1111;
  assign busy      = (state != ST_IDLE);
  assign sdio_pull = busy && in_wr && !wr_sh[MAXLEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      wl_q    <= '0;
      rl_q    <= '0;
      wr_sh   <= '0;
      rd_sh   <= '0;
      rd_data <= '0;
      done    <= 1'b0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state != ST_IDLE) cnt <= tick ? '0 : cnt + 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          wl_q  <= wl_c;
          rl_q  <= rl_c;
          wr_sh <= wr_data << (LENW'(MAXLEN) - wl_c);
          rd_sh <= '0;
          idx   <= '0;
          cnt   <= '0;
          cs_n  <= 1'b0;
          state <= ST_SETUP;
        end
        ST_SETUP: if (tick) begin
          if (total == '0) state <= ST_TAIL;
          else begin
            sclk  <= 1'b1;
            if (!in_wr) rd_sh <= {rd_sh[MAXLEN-2:0], rx_bit};
            state <= ST_HIGH;
          end
        end
        ST_HIGH: if (tick) begin
          sclk  <= 1'b0;
          wr_sh <= wr_sh << 1;
          idx   <= idx + 1'b1;
          state <= last ? ST_TAIL : ST_LOW;
        end
        ST_LOW: if (tick) begin
          sclk  <= 1'b1;
          if (!in_wr) rd_sh <= {rd_sh[MAXLEN-2:0], rx_bit};
          state <= ST_HIGH;
        end
        ST_TAIL: if (tick) begin
          cs_n    <= 1'b1;
          done    <= 1'b1;
          rd_data <= rd_sh;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_PWR_HIGH: assert property (@(posedge clk) pwr == 4'b1111); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk && !sdio_pull)); // R2
  AST_PULL_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdio_pull)); // R3
  AST_SCLK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n); // R4
  AST_CS_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sclk && !$past(sclk))); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(wl_q) && $stable(rl_q))); // R10

endmodule

// File: tb/test_spi3w_master.sv
module test_spi3w_master;
  localparam int DIV = 4;
  localparam int HP  = 20;

  logic clk = 0, rst_n = 0, start = 0;
  logic [4:0] wr_len = 0, rd_len = 0;
  logic [15:0] wr_data = 0;
  logic busy, done, cs_n, sclk, sdio_pull, sdio_inv;
  logic [15:0] rd_data;
  logic [3:0] pwr;

  always #10 clk = ~clk;

  spi3w_master #(.DIV(DIV), .MAXLEN(16)) i_spi3w_master (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_len(wr_len), .rd_len(rd_len),
    .wr_data(wr_data), .busy(busy), .done(done), .rd_data(rd_data), .cs_n(cs_n),
    .sclk(sclk), .sdio_pull(sdio_pull), .sdio_inv(sdio_inv), .pwr(pwr));

  int nvec = 0, nfail = 0;
  task automatic chk(bit ok, string tag, longint act, longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] msk(int n);
    return (n >= 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
  endfunction

  // peripheral model: wired-low line with inverting readback
  int pwl = 0, prl = 0, f = 0;
  logic [15:0] resp = 0;
  logic per_low;
  always_comb begin
    per_low = 1'b0;
    if (cs_n === 1'b0 && f >= pwl && f < pwl + prl)
      per_low = !resp[prl - 1 - (f - pwl)];
  end
  assign sdio_inv = sdio_pull | per_low;

  time t_csfall = 0, t_rise1 = 0, t_prise = 0, t_lastfall = 0, t_csrise = 0;
  int rises = 0, ncs = 0;
  bit bad_gap = 0, bad_release = 0;
  logic [15:0] cap = 0;

  always @(negedge sclk or posedge cs_n) begin
    if (cs_n === 1'b1) f = 0;
    else if (cs_n === 1'b0) begin f = f + 1; t_lastfall = $time; end
  end

  always @(negedge cs_n) begin
    t_csfall = $time; ncs++;
    rises = 0; cap = 0; bad_gap = 0; bad_release = 0;
  end
  always @(posedge cs_n) t_csrise = $time;

  always @(posedge sclk) begin
    if (cs_n === 1'b0) begin
      if (rises == 0) t_rise1 = $time;
      else if ($time - t_prise != 2 * DIV * HP) bad_gap = 1;
      t_prise = $time;
      rises++;
      if (f < pwl) cap = {cap[14:0], ~sdio_inv};
      else if (sdio_pull) bad_release = 1;
    end
  end

  // scoreboard
  logic [15:0] q_cmd[$], q_rd[$];
  int q_n[$];
  int ntxn = 0;
  bit prev_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done) chk(0, "R9 done longer than one cycle", 1, 0);
      if (done) begin
        if (q_n.size() == 0) chk(0, "R10 unexpected transaction", 1, 0);
        else begin
          automatic logic [15:0] ec = q_cmd.pop_front();
          automatic logic [15:0] er = q_rd.pop_front();
          automatic int en = q_n.pop_front();
          chk(rd_data == er, "R6 response word", rd_data, er);
          chk(cap == ec, "R5 command bits", cap, ec);
          chk(rises == en, "R11 rising edge count", rises, en);
          chk(!busy, "R9 busy low with done", busy, 0);
          chk(!bad_release, "R6 line released in read", bad_release, 0);
          chk(pwr == 4'hF, "R1 supply pins", pwr, 4'hF);
          if (en > 0) begin
            chk((t_rise1 - t_csfall) == DIV * HP, "R4 lead gap", t_rise1 - t_csfall, DIV * HP);
            chk((t_csrise - t_lastfall) == DIV * HP, "R4 trail gap", t_csrise - t_lastfall, DIV * HP);
            chk(!bad_gap, "R3 clock period", bad_gap, 0);
          end else
            chk((t_csrise - t_csfall) == 2 * DIV * HP, "R7 empty chip-select pulse", t_csrise - t_csfall, 2 * DIV * HP);
        end
      end
      prev_done = done;
    end
  end

  task automatic run(int wl, int rl, logic [15:0] d, logic [15:0] r, bit poke);
    int cwl = (wl > 16) ? 16 : wl;
    int crl = (rl > 16) ? 16 : rl;
    @(negedge clk);
    while (busy) @(negedge clk);
    pwl = cwl; prl = crl; resp = r;
    q_cmd.push_back(d & msk(cwl));
    q_rd.push_back(r & msk(crl));
    q_n.push_back(cwl + crl);
    ntxn++;
    wr_len = 5'(wl); rd_len = 5'(rl); wr_data = d; start = 1;
    @(negedge clk); start = 0;
    chk(busy && !cs_n, "R9 busy after start", {busy, cs_n}, 2'b10);
    if (poke) begin
      repeat (20) @(negedge clk);
      wr_len = 5'd2; rd_len = 5'd2; wr_data = 16'hFFFF; start = 1; // R10
      @(negedge clk); start = 0;
    end
    @(posedge done);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pwr == 4'hF, "R1 supply in reset", pwr, 4'hF);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1, "R2 idle cs_n", cs_n, 1);
    chk(sclk == 0, "R2 idle sclk", sclk, 0);
    chk(busy == 0, "R2 idle busy", busy, 0);
    chk(done == 0, "R2 idle done", done, 0);
    chk(sdio_pull == 0, "R2 idle line released", sdio_pull, 0);
    run(8, 16, 16'h00B3, 16'hC35A, 0);
    run(0, 8, 16'hFFFF, 16'h0096, 0);   // R7 read first
    run(16, 16, 16'h8001, 16'h7FFE, 0);
    run(8, 0, 16'h005C, 16'h0000, 0);
    run(0, 0, 16'h1234, 16'hFFFF, 0);   // R7 empty
    run(3, 5, 16'hFFF5, 16'hFFF3, 0);
    run(20, 25, 16'h1234, 16'hBEEF, 0); // R8 clamp
    run(1, 1, 16'h0000, 16'h0001, 0);
    run(8, 8, 16'h00A6, 16'h0059, 1);   // R10 start while busy
    repeat (40) @(negedge clk);
    chk(ncs == ntxn, "R10 chip-select pulse count", ncs, ntxn);
    chk(q_n.size() == 0, "R10 missing completions", q_n.size(), 0);
    chk(cs_n == 1 && !busy, "R2 idle after run", {cs_n, busy}, 2'b10);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule